// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a register-to-register synchronous static RAM with a 32-bit data path made of four byte lanes. On every rising clock edge it captures the address, the write data and all synchronous controls. From those captured values it works out what kind of cycle it is: an idle cycle, a deselect, the start of a read or a write at an externally supplied address, a burst step to the next internal address, or a burst hold at the current address. A 2-bit burst counter replaces the two low address bits during a burst. It counts in linear or interleaved order, chosen by a static mode input.

Writes merge byte lanes. A global write stores all four lanes, and a byte-masked write stores only the lanes that are selected. Read data goes through an output register, so a read whose controls are captured at edge k appears on the output after edge k+1. An asynchronous output-enable input decides, without waiting for a clock, whether the bus would be driven. The block gives the bus value and a drive-enable flag. The tri-state pad itself sits outside the block.

The intended use is as a cache data store behind a processor bus. The processor-side strobe starts reads. The controller-side strobe starts reads or writes. Advance steps through a four-word line.

Top module: `burst_pipe_sram`

## Requirements
- R1: After reset `dq_oe` is 0 and no burst is active. A cycle with both strobes high while no burst is active performs no access and drives nothing.
- R2: A cycle with `proc_strb_n` low while `en_pri_n` is high is a deselect, whatever the other inputs are. The bus is not driven for it, and the burst ends, so a later advance performs no access.
- R3: A cycle where a strobe is accepted but any enable is inactive (`en_pri_n` high, `en_hi` low or `en_lo_n` high) is a deselect. It has the same no-drive and end-of-burst effect as R2.
- R4: With all enables active, `proc_strb_n` low starts a read at `addr_in` and ignores the write controls. The word is on `dq_out` with `dq_oe` high after the clock edge that follows the edge that captured the request.
- R5: With all enables active, `ctrl_strb_n` low and `proc_strb_n` high starts an access at `addr_in`. The access is a write when the captured write controls request one (R9) and a read otherwise. Write data is taken from the same cycle.
- R6: When both strobes are high during a burst, `adv_n` low moves to the next burst address and `adv_n` high repeats the current address. The three enables are ignored in these cycles. Each such cycle reads or writes according to its own write controls.
- R7: With `order_ilv` = 0 the low two address bits count up modulo 4 from the loaded value (for example 01, 10, 11, 00).
- R8: With `order_ilv` = 1 the low two address bits equal the loaded value XOR the step count (for example 01, 00, 11, 10).
- R9: `gw_n` low writes all four lanes. Otherwise `we_n` low writes only the lanes whose `be_n` bit is low, where `be_n[i]` controls `dq` bits 8i+7 to 8i. If `we_n` is low with `be_n` = 4'b1111, the cycle is a read.
- R10: `dq_oe` is high only while the output register holds read data and `oe_n` is low. It follows `oe_n` with no clock edge in between. It is low for the results of write and deselect cycles.
- R11: A strobe that arrives during a burst takes priority over `adv_n` and starts a new burst at `addr_in`.
- R12: During a burst, the address bits above bit 1 stay at the values loaded when the burst began, so the burst wraps within its four-word block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs captured on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External word address |
| wdata_in | input | DATA_W | Write data |
| proc_strb_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en_pri_n | input | 1 | Primary enable, active low; also blocks the processor strobe |
| en_hi | input | 1 | Depth enable, active high |
| en_lo_n | input | 1 | Depth enable, active low |
| gw_n | input | 1 | Global write, active low |
| we_n | input | 1 | Byte-write qualifier, active low |
| be_n | input | DATA_W/8 | Byte-lane selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| dq_out | output | DATA_W | Output register contents |
| dq_oe | output | 1 | Bus drive enable for the external pad |

## Verification
Two functions can land in the same cycle. The first is a burst step, where advance is low and a burst is running. The second is a new address strobe. The bench provokes this by asserting the controller strobe with `adv_n` low in the middle of a read burst. The returned word must come from the new external address and not from the next burst address. A second overlap is a write commit followed at once by a strobe-started read of the word just written. That read must return the merged lanes with no stale data. Deselects placed between bursts confirm that the pipelined output of the earlier read still shows while the new request is being captured.

// File: rtl/pbs_pkg.sv
// Shared types and helpers for the pipelined burst SRAM.
// Assumes a two-bit burst field held in the lowest address bits.
package pbs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        CYC_IDLE     = 3'd0,
        CYC_DESEL    = 3'd1,
        CYC_BEGIN_RD = 3'd2,
        CYC_BEGIN_WR = 3'd3,
        CYC_CONT     = 3'd4,
        CYC_SUSP     = 3'd5
    } cyc_e;

    // Low two address bits for a given step of the burst.
    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       interleave);
        return interleave ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/pbs_decode.sv
// Cycle decoder: turns the captured strobes, enables and write controls
// into a cycle kind, a read/write request and a byte-lane mask.
// Assumes all inputs come from the input register stage.
module pbs_decode #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               proc_n,
    input  logic               ctrl_n,
    input  logic               adv_n,
    input  logic               en_pri_n,
    input  logic               en_hi,
    input  logic               en_lo_n,
    input  logic               gw_n,
    input  logic               we_n,
    input  logic [LANES-1:0]   be_n,
    input  logic               sel,
    output pbs_pkg::cyc_e      kind,
    output logic               wr_en,
    output logic               rd_en,
    output logic [LANES-1:0]   wmask
);
    import pbs_pkg::*;

    logic             wants_wr;
    logic             enables_ok;
    logic             in_burst;
    logic [LANES-1:0] lane_sel;

    // Write request and lane selection from the write controls.
    always_comb begin
        wants_wr = !gw_n || (!we_n && (be_n != {LANES{1'b1}}));
        if (!gw_n)
            lane_sel = {LANES{1'b1}};
        else if (!we_n)
            lane_sel = ~be_n;
        else
            lane_sel = '0;
    end

    // Cycle kind: strobes first, then burst step or hold.
    always_comb begin
        enables_ok = !en_pri_n && en_hi && !en_lo_n;
        if (!proc_n && en_pri_n)
            kind = CYC_DESEL;
        else if (!proc_n)
            kind = enables_ok ? CYC_BEGIN_RD : CYC_DESEL;
        else if (!ctrl_n)
            kind = enables_ok ? (wants_wr ? CYC_BEGIN_WR : CYC_BEGIN_RD) : CYC_DESEL;
        else if (sel)
            kind = adv_n ? CYC_SUSP : CYC_CONT;
        else
            kind = CYC_IDLE;
    end

    // Array request derived from the cycle kind.
    always_comb begin
        in_burst = (kind == CYC_CONT) || (kind == CYC_SUSP);
        wr_en    = (kind == CYC_BEGIN_WR) || (in_burst && wants_wr);
        rd_en    = (kind == CYC_BEGIN_RD) || (in_burst && !wants_wr);
        wmask    = wr_en ? lane_sel : '0;
    end

    AST_WR_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wmask != '0)); // R9
    AST_PROC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_n && en_pri_n) |-> (!rd_en && !wr_en)); // R2
    AST_DESEL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_DESEL) |=> !sel); // R3

endmodule

// File: rtl/pbs_burst.sv
// Burst address generator: loads the external address on a begin cycle,
// steps or holds a two-bit counter, and forms the array address.
// Assumes the order select is static during a burst.
module pbs_burst #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pbs_pkg::cyc_e     kind,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              interleave,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              sel
);
    import pbs_pkg::*;

    logic [ADDR_W-1:0] base_q, base_n;
    logic [1:0]        cnt_q, cnt_n;
    logic              sel_q;
    logic              is_begin;

    // Next base, next step count and the resulting access address.
    always_comb begin
        is_begin = (kind == CYC_BEGIN_RD) || (kind == CYC_BEGIN_WR);
        base_n   = is_begin ? ext_addr : base_q;
        if (is_begin)
            cnt_n = 2'd0;
        else if (kind == CYC_CONT)
            cnt_n = cnt_q + 2'd1;
        else
            cnt_n = cnt_q;
        acc_addr = {base_n[ADDR_W-1:2], burst_lo(base_n[1:0], cnt_n, interleave)};
    end

    // Burst state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
            sel_q  <= 1'b0;
        end else begin
            base_q <= base_n;
            cnt_q  <= cnt_n;
            if (is_begin)
                sel_q <= 1'b1;
            else if (kind == CYC_DESEL)
                sel_q <= 1'b0;
        end
    end

    assign sel = sel_q;

    AST_CONT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_CONT) |=> (cnt_q == $past(cnt_q) + 2'd1)); // R6
    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_SUSP) |=> $stable(cnt_q)); // R6
    AST_BEGIN_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        is_begin |=> (sel_q && cnt_q == 2'd0)); // R4
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_CONT) |=> (base_q[ADDR_W-1:2] == $past(base_q[ADDR_W-1:2]))); // R12

endmodule

// File: rtl/pbs_array.sv
// Storage array with per-lane write merge and a registered read port.
// Assumes read and write requests are never raised in the same cycle.
module pbs_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [LANES-1:0]              wmask,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [LANES*pbs_pkg::BYTE_W-1:0] wdata,
    output logic [LANES*pbs_pkg::BYTE_W-1:0] q,
    output logic                          rd_vld
);
    import pbs_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam int DW    = LANES * BYTE_W;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] merged;

    // One merge mux per lane: new byte if selected, else stored byte.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            merged[g*BYTE_W +: BYTE_W] = wmask[g] ? wdata[g*BYTE_W +: BYTE_W]
                                                  : mem[addr][g*BYTE_W +: BYTE_W];
        end
    end

    // Array write of the merged word.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[addr] <= merged;
    end

    // Output register: loads only on reads.
    always_ff @(posedge clk) begin
        if (rd_en)
            q <= mem[addr];
    end

    // Read-valid flag for the output stage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_vld <= 1'b0;
        else
            rd_vld <= rd_en;
    end

    AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !rd_vld); // R10
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_en, wr_en})); // R9

endmodule

// File: rtl/burst_pipe_sram.sv
// Pipelined burst synchronous SRAM top: input register stage, cycle
// decode, burst addressing, array and asynchronous output-enable gate.
// Assumes order_ilv is tied static and oe_n is asynchronous.
module burst_pipe_sram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr_in,
    input  logic [DATA_W-1:0]     wdata_in,
    input  logic                  proc_strb_n,
    input  logic                  ctrl_strb_n,
    input  logic                  adv_n,
    input  logic                  en_pri_n,
    input  logic                  en_hi,
    input  logic                  en_lo_n,
    input  logic                  gw_n,
    input  logic                  we_n,
    input  logic [DATA_W/8-1:0]   be_n,
    input  logic                  oe_n,
    input  logic                  order_ilv,
    output logic [DATA_W-1:0]     dq_out,
    output logic                  dq_oe
);
    import pbs_pkg::*;

    localparam int LANES = DATA_W / BYTE_W;

    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic              r_proc_n, r_ctrl_n, r_adv_n;
    logic              r_en_pri_n, r_en_hi, r_en_lo_n;
    logic              r_gw_n, r_we_n;
    logic [LANES-1:0]  r_be_n;

    cyc_e              kind;
    logic              wr_en, rd_en, sel, rd_vld;
    logic [LANES-1:0]  wmask;
    logic [ADDR_W-1:0] acc_addr;

    // Input register stage for all synchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr     <= '0;
            r_wdata    <= '0;
            r_proc_n   <= 1'b1;
            r_ctrl_n   <= 1'b1;
            r_adv_n    <= 1'b1;
            r_en_pri_n <= 1'b1;
            r_en_hi    <= 1'b0;
            r_en_lo_n  <= 1'b1;
            r_gw_n     <= 1'b1;
            r_we_n     <= 1'b1;
            r_be_n     <= '1;
        end else begin
            r_addr     <= addr_in;
            r_wdata    <= wdata_in;
            r_proc_n   <= proc_strb_n;
            r_ctrl_n   <= ctrl_strb_n;
            r_adv_n    <= adv_n;
            r_en_pri_n <= en_pri_n;
            r_en_hi    <= en_hi;
            r_en_lo_n  <= en_lo_n;
            r_gw_n     <= gw_n;
            r_we_n     <= we_n;
            r_be_n     <= be_n;
        end
    end

    pbs_decode #(.LANES(LANES)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .proc_n   (r_proc_n),
        .ctrl_n   (r_ctrl_n),
        .adv_n    (r_adv_n),
        .en_pri_n (r_en_pri_n),
        .en_hi    (r_en_hi),
        .en_lo_n  (r_en_lo_n),
        .gw_n     (r_gw_n),
        .we_n     (r_we_n),
        .be_n     (r_be_n),
        .sel      (sel),
        .kind     (kind),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wmask    (wmask)
    );

    pbs_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .ext_addr   (r_addr),
        .interleave (order_ilv),
        .acc_addr   (acc_addr),
        .sel        (sel)
    );

    pbs_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wmask  (wmask),
        .addr   (acc_addr),
        .wdata  (r_wdata),
        .q      (dq_out),
        .rd_vld (rd_vld)
    );

    // Asynchronous output-enable gate on the registered read flag.
    always_comb dq_oe = rd_vld && !oe_n;

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !oe_n) |=> (dq_oe || oe_n)); // R4
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_DESEL) |=> !dq_oe); // R3

endmodule

// File: tb/tb_burst_pipe_sram.sv
`timescale 1ns/1ps
module tb_burst_pipe_sram;

    localparam int AW = 10;
    localparam int DW = 32;
    localparam int VW = 54;
    localparam int NROWS = 21;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_in;
    logic [DW-1:0] wdata_in;
    logic          proc_strb_n, ctrl_strb_n, adv_n;
    logic          en_pri_n, en_hi, en_lo_n;
    logic          gw_n, we_n;
    logic [3:0]    be_n;
    logic          oe_n, order_ilv;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    always #4 clk = ~clk;

    burst_pipe_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .wdata_in(wdata_in),
        .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
        .en_pri_n(en_pri_n), .en_hi(en_hi), .en_lo_n(en_lo_n),
        .gw_n(gw_n), .we_n(we_n), .be_n(be_n), .oe_n(oe_n),
        .order_ilv(order_ilv), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [DW-1:0] ref_mem [1<<AW];
    bit            m_sel = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = 2'd0;

    // Pending expectation (result appears one clock after capture)
    bit            p_valid = 1'b0;
    bit            p_rd;
    logic [DW-1:0] p_data;
    string         p_tag;

    // Vector: ps cs adv e1n e2 e3n gw we be[4] addr[10] data[32]
    function automatic logic [VW-1:0] mk(logic ps, logic cs, logic adv, logic e1n,
                                         logic e2, logic e3n, logic gw, logic we,
                                         logic [3:0] be, logic [AW-1:0] a, logic [DW-1:0] d);
        return {ps, cs, adv, e1n, e2, e3n, gw, we, be, a, d};
    endfunction

    localparam logic [VW-1:0] TABLE [NROWS] = '{
        mk(1,0,1,0,1,0, 0,1,4'hF, 10'h040, 32'hA0A0_0040), // begin write all lanes
        mk(1,1,0,0,1,0, 0,1,4'hF, 10'h000, 32'hA0A0_0041), // continue write
        mk(1,1,0,0,1,0, 0,1,4'hF, 10'h000, 32'hA0A0_0042),
        mk(1,1,0,0,1,0, 0,1,4'hF, 10'h000, 32'hA0A0_0043),
        mk(0,1,1,1,1,0, 1,1,4'hF, 10'h000, 32'h0),         // blocked proc strobe
        mk(0,1,1,0,1,0, 0,0,4'h0, 10'h041, 32'hFFFF_FFFF), // proc read, write ctrls ignored
        mk(1,1,0,0,1,0, 1,1,4'hF, 10'h000, 32'h0),         // -> 042
        mk(1,1,0,0,1,0, 1,1,4'hF, 10'h000, 32'h0),         // -> 043
        mk(1,1,0,0,1,0, 1,1,4'hF, 10'h000, 32'h0),         // -> 040 wrap
        mk(1,1,1,0,1,0, 1,1,4'hF, 10'h000, 32'h0),         // hold 040
        mk(1,1,0,1,0,1, 1,1,4'hF, 10'h000, 32'h0),         // -> 041, enables off
        mk(1,0,0,0,1,0, 1,1,4'hF, 10'h042, 32'h0),         // strobe beats advance
        mk(1,0,1,0,1,0, 1,0,4'hD, 10'h043, 32'h0000_5500), // lane-1 write
        mk(1,0,1,1,1,0, 1,1,4'hF, 10'h000, 32'h0),         // ctrl strobe, e1n off
        mk(0,1,1,0,1,0, 1,1,4'hF, 10'h043, 32'h0),         // read merged word
        mk(1,0,1,0,1,0, 1,0,4'hF, 10'h040, 32'h0),         // we low, no lane: read
        mk(1,0,1,0,1,1, 1,1,4'hF, 10'h000, 32'h0),         // e3n off
        mk(1,1,0,0,1,0, 1,1,4'hF, 10'h000, 32'h0),         // advance with no burst
        mk(1,0,1,0,1,0, 0,0,4'hE, 10'h041, 32'h1234_5678), // global write overrides
        mk(0,1,1,0,1,0, 1,1,4'hF, 10'h041, 32'h0),         // read back
        mk(0,1,1,1,1,0, 1,1,4'hF, 10'h000, 32'h0)          // deselect
    };

    localparam logic [VW-1:0] DESEL_V = 54'h0;

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model for one captured cycle.
    task automatic model(input logic [VW-1:0] v, output bit rd,
                         output logic [DW-1:0] d, output string tag);
        logic ps, cs, adv, e1n, e2, e3n, gw, we;
        logic [3:0] be;
        logic [AW-1:0] a, acc;
        logic [DW-1:0] wd;
        logic [1:0] lo;
        bit w;
        int act;
        {ps, cs, adv, e1n, e2, e3n, gw, we, be, a, wd} = v;
        w   = !gw || (!we && be != 4'hF);
        act = 0;
        acc = '0;
        rd  = 1'b0;
        d   = '0;
        if (!ps && e1n) begin
            m_sel = 1'b0; tag = "R2";
        end else if (!ps || !cs) begin
            if (e1n || !e2 || e3n) begin
                m_sel = 1'b0; tag = "R3";
            end else begin
                tag = m_sel ? "R11" : (!ps ? "R4" : "R5");
                m_sel = 1'b1; m_base = a; m_cnt = 2'd0; acc = a;
                act = (!ps || !w) ? 1 : 2;
                if (ps && !we && gw && be == 4'hF) tag = "R9";
            end
        end else if (m_sel) begin
            if (!adv) m_cnt = m_cnt + 2'd1;
            lo  = order_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
            acc = {m_base[AW-1:2], lo};
            act = w ? 2 : 1;
            if (adv) tag = "R6";
            else if (order_ilv) tag = "R8";
            else if (lo < m_base[1:0]) tag = "R12";
            else tag = "R7";
        end else begin
            tag = "R1";
        end
        if (act == 2) begin
            for (int i = 0; i < 4; i++)
                if (!gw || !be[i]) ref_mem[acc][i*8 +: 8] = wd[i*8 +: 8];
        end else if (act == 1) begin
            rd = 1'b1;
            d  = ref_mem[acc];
        end
    endtask

    // Drive one cycle at the falling edge and check the previous cycle's result.
    task automatic cyc(input logic [VW-1:0] v);
        bit c_rd;
        logic [DW-1:0] c_d;
        string c_tag;
        {proc_strb_n, ctrl_strb_n, adv_n, en_pri_n, en_hi, en_lo_n,
         gw_n, we_n, be_n, addr_in, wdata_in} = v;
        model(v, c_rd, c_d, c_tag);
        @(posedge clk);
        @(negedge clk);
        if (p_valid) begin
            check(p_tag, "drive", {31'b0, dq_oe}, {31'b0, p_rd});
            if (p_rd) check(p_tag, "data", dq_out, p_data);
        end
        p_valid = 1'b1; p_rd = c_rd; p_data = c_d; p_tag = c_tag;
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        oe_n = 1'b0;
        order_ilv = 1'b0;
        {proc_strb_n, ctrl_strb_n, adv_n, en_pri_n, en_hi, en_lo_n,
         gw_n, we_n, be_n, addr_in, wdata_in} = mk(1,1,1,0,1,0,1,1,4'hF,10'h0,32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, bus not driven
        check("R1", "reset drive", {31'b0, dq_oe}, 32'h0);

        // R1: advance with no burst after reset
        cyc(mk(1,1,0,0,1,0,1,1,4'hF,10'h0,32'h0));
        cyc(mk(0,1,1,1,1,0,1,1,4'hF,10'h0,32'h0));

        // Linear-order table
        for (int i = 0; i < NROWS; i++) cyc(TABLE[i]);

        // R10: asynchronous output enable on a held read result
        cyc(mk(0,1,1,0,1,0,1,1,4'hF,10'h040,32'h0));
        cyc(mk(0,1,1,1,1,0,1,1,4'hF,10'h0,32'h0));
        oe_n = 1'b1;
        #1 check("R10", "oe high", {31'b0, dq_oe}, 32'h0);
        oe_n = 1'b0;
        #1 check("R10", "oe low", {31'b0, dq_oe}, 32'h1);

        // R10: write result not driven
        cyc(mk(1,0,1,0,1,0,0,1,4'hF,10'h044,32'hCAFE_0044));

        // R8: interleaved order from 01: 041, 040, 043, 042
        order_ilv = 1'b1;
        cyc(mk(0,1,1,0,1,0,1,1,4'hF,10'h041,32'h0));
        for (int k = 0; k < 3; k++) cyc(mk(1,1,0,0,1,0,1,1,4'hF,10'h0,32'h0));
        cyc(mk(1,1,1,0,1,0,1,1,4'hF,10'h0,32'h0));
        cyc(mk(0,1,1,1,1,0,1,1,4'hF,10'h0,32'h0));
        cyc(DESEL_V | mk(0,1,1,1,1,0,1,1,4'hF,10'h0,32'h0));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule